// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block turns sixteen interrupt request lines into one interrupt output and a 4-bit line number. The lines form two groups of eight. The second group does not reach the host directly. It feeds input 2 of the first group, so its eight lines share that single slot in the first group's ranking. Input 2 is therefore never a device line. Requests are captured on rising edges and held as pending while their line stays high. Pending requests compete by a fixed cascaded ranking, from highest to lowest: 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.

The host sees `int_out` and `vector` and takes the current winner with a one-cycle `ack` pulse. The winner then moves from pending to in-service. While a level is in service, that level and every lower level are held back. A one-cycle `eoi` pulse retires the most urgent in-service level. A 16-bit mask register keeps lines out of arbitration without discarding what they have pending. Lines 0 and 1 carry the system tick and the keyboard buffer, which is why they sit above the whole second group.

Top module: `irq_cascade_resolver`

## Requirements
- R1: A low-to-high change of `irq[n]` that is sampled at a clock edge sets line n pending. After that same edge, `int_out` rises if line n is the best eligible request.
- R2: A pending line whose `irq` input is sampled low at an edge before it is acknowledged is removed from pending. It raises no interrupt afterwards.
- R3: Input `irq[2]` is the cascade slot and has no effect. It never becomes pending, and `vector` never reads 2 while `int_out` is high.
- R4: Among eligible lines, the winner follows the ranking 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7 (first is most urgent).
- R5: `int_out` is high exactly when at least one eligible line exists. `vector` carries the winner's line number in binary and reads 0 while `int_out` is low.
- R6: An `ack` sampled while `int_out` is high clears the winner's pending bit and sets its in-service bit. An `ack` while `int_out` is low changes nothing.
- R7: A pending line is eligible only if it is unmasked and strictly more urgent than every in-service line.
- R8: An `eoi` sampled while any line is in service clears only the most urgent in-service bit. Any less urgent in-service line keeps blocking.
- R9: `mask_we` loads `mask_in` into the mask register; bit n set excludes line n. The new mask acts after the loading edge. Masking keeps pending state, so unmasking brings back a request that is still pending.
- R10: After reset, nothing is pending, nothing is in service, the mask is all zero, `int_out` is low and `vector` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 16 | Interrupt request lines, active high |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_in | input | 16 | New mask value, bit n excludes line n |
| ack | input | 1 | Host takes the current winner |
| eoi | input | 1 | Host retires the most urgent in-service level |
| int_out | output | 1 | An eligible request exists |
| vector | output | 4 | Line number of the winning request |

## Verification
A wrong pending, in-service or mask bit shows up at the ports in the cycle after the edge that stored it. It appears either as a different `vector` or as `int_out` being high when nothing is eligible, or low when something is. A stale in-service bit is the quiet case: it only shows when a later request of equal or lower urgency is held back when it should win. The random phase therefore issues acknowledges without matching retires, so that in-service state builds up over many cycles, and compares both outputs on every cycle.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    localparam int unsigned GROUP_LINES = 8;
    localparam int unsigned NUM_LINES   = 2 * GROUP_LINES;
    localparam int unsigned CASCADE_IN  = 2;
    localparam int unsigned IDX_W       = $clog2(NUM_LINES);

    typedef logic [NUM_LINES-1:0] line_vec_t;
    typedef logic [IDX_W-1:0]     line_idx_t;

    typedef struct packed {
        line_vec_t pend;
        line_vec_t isr;
        line_vec_t mask;
    } res_state_t;

    // Rank of a line: 0 is most urgent. The second group is ranked
    // inside the cascade slot; the cascade input gets the last rank.
    function automatic line_idx_t rank_of(input int unsigned line);
        int unsigned r;
        if (line < CASCADE_IN)
            r = line;
        else if (line == CASCADE_IN)
            r = NUM_LINES - 1;
        else if (line >= GROUP_LINES)
            r = CASCADE_IN + (line - GROUP_LINES);
        else
            r = line - 1 + GROUP_LINES;
        return line_idx_t'(r);
    endfunction

    // Inverse of rank_of.
    function automatic line_idx_t line_of(input int unsigned rank);
        int unsigned l;
        if (rank < CASCADE_IN)
            l = rank;
        else if (rank < CASCADE_IN + GROUP_LINES)
            l = GROUP_LINES + (rank - CASCADE_IN);
        else if (rank < NUM_LINES - 1)
            l = rank - GROUP_LINES + 1;
        else
            l = CASCADE_IN;
        return line_idx_t'(l);
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_res_pkg::*;
#(
    parameter int unsigned N    = NUM_LINES,
    parameter int unsigned SKIP = CASCADE_IN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq,
    output logic [N-1:0] rise,
    output logic [N-1:0] level
);
    localparam logic [N-1:0] KEEP = ~(N'(1) << SKIP);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = irq;
        rise   = irq & ~prev_q & KEEP;
        level  = irq & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_service_gate.sv
module irq_service_gate
    import irq_res_pkg::*;
#(
    parameter int unsigned N  = NUM_LINES,
    parameter int unsigned IW = IDX_W
) (
    input  logic          isr_found,
    input  logic [IW-1:0] isr_rank,
    output logic [N-1:0]  allowed
);
    for (genvar l = 0; l < N; l++) begin : g_line
        localparam logic [IW-1:0] MY_RANK = IW'(rank_of(l));
        assign allowed[l] = !isr_found || (MY_RANK < isr_rank);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_res_pkg::*;
#(
    parameter int unsigned N  = NUM_LINES,
    parameter int unsigned IW = IDX_W
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] line,
    output logic [IW-1:0] rank
);
    always_comb begin
        found = 1'b0;
        line  = '0;
        rank  = '0;
        // Walk from least to most urgent; the last hit is the winner.
        for (int r = N - 2; r >= 0; r--) begin
            if (req[line_of(r)]) begin
                found = 1'b1;
                line  = IW'(line_of(r));
                rank  = IW'(r);
            end
        end
    end
endmodule

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver
    import irq_res_pkg::*;
#(
    parameter int unsigned N  = NUM_LINES,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_in,
    input  logic          ack,
    input  logic          eoi,
    output logic          int_out,
    output logic [IW-1:0] vector
);
    res_state_t state_d, state_q;

    logic [N-1:0]  rise, level, allowed, eligible;
    logic          isr_found, win_found;
    logic [IW-1:0] isr_line, isr_rank, win_line, win_rank;

    // Plain copies of the state for the bound checker.
    logic [N-1:0] pend_vec, isr_vec, mask_vec;
    assign pend_vec = state_q.pend;
    assign isr_vec  = state_q.isr;
    assign mask_vec = state_q.mask;

    irq_edge_detect #(.N(N), .SKIP(CASCADE_IN)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .irq   (irq),
        .rise  (rise),
        .level (level)
    );

    irq_prio_pick #(.N(N), .IW(IW)) isr_pick_i (
        .req   (state_q.isr),
        .found (isr_found),
        .line  (isr_line),
        .rank  (isr_rank)
    );

    irq_service_gate #(.N(N), .IW(IW)) gate_i (
        .isr_found (isr_found),
        .isr_rank  (isr_rank),
        .allowed   (allowed)
    );

    assign eligible = state_q.pend & ~state_q.mask & allowed;

    irq_prio_pick #(.N(N), .IW(IW)) win_pick_i (
        .req   (eligible),
        .found (win_found),
        .line  (win_line),
        .rank  (win_rank)
    );

    always_comb begin
        state_d      = state_q;
        state_d.pend = (state_q.pend & level) | rise;
        if (eoi && isr_found)
            state_d.isr[isr_line] = 1'b0;
        if (ack && win_found) begin
            state_d.pend[win_line] = 1'b0;
            state_d.isr[win_line]  = 1'b1;
        end
        if (mask_we)
            state_d.mask = mask_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign int_out = win_found;
    assign vector  = win_found ? win_line : '0;

    logic unused_rank;
    assign unused_rank = ^win_rank;
endmodule

// File: rtl/irq_cascade_resolver_chk.sv
module irq_cascade_resolver_chk
    import irq_res_pkg::*;
#(
    parameter int unsigned N  = NUM_LINES,
    parameter int unsigned IW = IDX_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq,
    input logic          ack,
    input logic          eoi,
    input logic          int_out,
    input logic [IW-1:0] vector,
    input logic [N-1:0]  pend,
    input logic [N-1:0]  isr,
    input logic [N-1:0]  mask
);
    function automatic int best_rank(input logic [N-1:0] v);
        int b = N;
        for (int l = 0; l < N; l++)
            if (v[l] && int'(rank_of(l)) < b) b = int'(rank_of(l));
        return b;
    endfunction

    AST_CASCADE_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> vector != IW'(CASCADE_IN)); // R3

    AST_DROPPED_LINE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend & ~$past(irq)) == '0); // R2

    AST_IDLE_WITHOUT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> !int_out); // R5

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> pend[vector] && !mask[vector]); // R9

    AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        ack && int_out |=> isr[$past(vector)] && !pend[$past(vector)]); // R6

    AST_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> int'(rank_of(vector)) < best_rank(isr)); // R7

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi && !ack && (isr != '0) |=> $countones(isr) == $countones($past(isr)) - 1); // R8
endmodule

bind irq_cascade_resolver irq_cascade_resolver_chk #(.N(N), .IW(IW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .ack     (ack),
    .eoi     (eoi),
    .int_out (int_out),
    .vector  (vector),
    .pend    (pend_vec),
    .isr     (isr_vec),
    .mask    (mask_vec)
);

// File: tb/irq_cascade_resolver_tb.sv
module irq_cascade_resolver_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_in = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        int_out;
    logic [3:0]  vector;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state kept by the bench.
    logic [15:0] m_prev = '0, m_pend = '0, m_isr = '0, m_mask = '0;
    logic [15:0] cur_irq = '0;

    always #2 clk = ~clk;

    irq_cascade_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mask_we(mask_we), .mask_in(mask_in),
        .ack(ack), .eoi(eoi), .int_out(int_out), .vector(vector)
    );

    // Ranking from the requirement R4, most urgent first.
    function automatic int pos_of(input int line);
        int order [15] = '{0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7};
        for (int p = 0; p < 15; p++) if (order[p] == line) return p;
        return 99;
    endfunction

    function automatic int best(input logic [15:0] v);
        int b = -1;
        for (int l = 0; l < 16; l++)
            if (v[l] && (b < 0 || pos_of(l) < pos_of(b))) b = l;
        return b;
    endfunction

    function automatic int model_win();
        logic [15:0] elig;
        int top = best(m_isr);
        elig = m_pend & ~m_mask;
        for (int l = 0; l < 16; l++)
            if (top >= 0 && pos_of(l) >= pos_of(top)) elig[l] = 1'b0;
        return best(elig);
    endfunction

    task automatic cmp(input string tag, input logic exp_int, input logic [3:0] exp_vec);
        n_vec++;
        if (int_out !== exp_int || vector !== exp_vec) begin
            n_bad++;
            $display("FAIL %s: int_out=%0b vector=%0d expected int_out=%0b vector=%0d",
                     tag, int_out, vector, exp_int, exp_vec);
        end
    endtask

    // Apply one cycle of inputs, advance the model, compare outputs.
    task automatic step(input logic [15:0] i_irq, input logic i_ack, input logic i_eoi,
                        input logic i_mwe, input logic [15:0] i_mdat);
        logic [15:0] rise, pn, isn;
        int w, t;
        irq = i_irq; ack = i_ack; eoi = i_eoi; mask_we = i_mwe; mask_in = i_mdat;
        rise = i_irq & ~m_prev;
        rise[2] = 1'b0;
        pn = (m_pend & i_irq) | rise;
        pn[2] = 1'b0;
        isn = m_isr;
        w = model_win();
        t = best(m_isr);
        if (i_eoi && t >= 0) isn[t] = 1'b0;
        if (i_ack && w >= 0) begin pn[w] = 1'b0; isn[w] = 1'b1; end
        @(negedge clk);
        m_prev = i_irq; m_pend = pn; m_isr = isn;
        if (i_mwe) m_mask = i_mdat;
        w = model_win();
        cmp("R5 model", w >= 0, (w >= 0) ? 4'(w) : 4'd0);
    endtask

    task automatic hold(input logic i_ack, input logic i_eoi);
        step(cur_irq, i_ack, i_eoi, 1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        cmp("R10 reset", 1'b0, 4'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R10 after release", 1'b0, 4'd0);

        // R3: cascade input is ignored
        cur_irq = 16'h0004; hold(0, 0);
        cmp("R3 line2 ignored", 1'b0, 4'd0);
        cur_irq = '0; hold(0, 0);

        // R1 / R4: several edges at once
        cur_irq = 16'h8088; hold(0, 0);
        cmp("R1 edge raises", 1'b1, 4'd15);
        cur_irq |= 16'h0100; hold(0, 0);
        cmp("R4 line8 beats 15 and 3", 1'b1, 4'd8);
        cur_irq |= 16'h0002; hold(0, 0);
        cmp("R4 line1 beats line8", 1'b1, 4'd1);

        // R6 / R7 / R8
        hold(1, 0);
        cmp("R7 line1 in service blocks lower", 1'b0, 4'd0);
        cur_irq |= 16'h0001; hold(0, 0);
        cmp("R7 line0 passes service", 1'b1, 4'd0);
        hold(1, 0);
        cmp("R6 ack moves line0", 1'b0, 4'd0);
        hold(0, 1);
        cmp("R8 eoi retires line0, line1 still blocks", 1'b0, 4'd0);
        hold(0, 1);
        cmp("R8 second eoi frees line8", 1'b1, 4'd8);

        // R2: drop before ack
        cur_irq &= ~16'h0100; hold(0, 0);
        cmp("R2 dropped line8", 1'b1, 4'd15);

        // R9: mask keeps pending
        step(cur_irq, 0, 0, 1'b1, 16'h8000);
        cmp("R9 masked line15", 1'b1, 4'd3);
        step(cur_irq, 0, 0, 1'b1, 16'h0000);
        cmp("R9 unmask restores line15", 1'b1, 4'd15);

        // R6: ack while idle is ignored
        cur_irq = '0; hold(0, 0);
        cmp("R2 all dropped", 1'b0, 4'd0);
        hold(1, 0);
        cmp("R6 idle ack", 1'b0, 4'd0);
        cur_irq = 16'h0010; hold(0, 0);
        cmp("R6 idle ack left no service", 1'b1, 4'd4);
        cur_irq = '0; hold(0, 0);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] nx;
            nx = cur_irq;
            for (int b = 0; b < 16; b++)
                if ($urandom % 8 == 0) nx[b] = ~nx[b];
            cur_irq = nx;
            step(cur_irq, ($urandom % 4) == 0, ($urandom % 6) == 0,
                 ($urandom % 24) == 0, 16'($urandom & $urandom & $urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule